// File: doc/BRIEF.md
# Comba Scheduled Wide Multiplier

This block multiplies two wide unsigned operands over several clock cycles. Each operand is split into 16-bit words. One multiply lane is provided per operand word, and each lane forms one 16x16 product per cycle. The A words stay fixed in their lanes. The B words drain out of a holding register toward lane 0 and are fed into a travel register that moves them up through the lanes, the opposite direction. Because of this, the lanes cover one product column per cycle, in column order. Column `i` is the sum of every `a_k*b_(i-k)` whose indices are valid.

Each column sum is registered at a width that leaves guard bits for the lane count. The registered column is then shifted left by 16·i bits and added into a double-width accumulator. A single start pulse loads both operands. When the product is ready, a one-cycle done pulse appears, and the product stays on the output until the next result replaces it. The block is not pipelined, so one multiplication runs at a time.

Top module: `comba_mult`

## Requirements
- R1: After a run, `prod_o` equals the full 2·OP_W-bit unsigned product of the `a_i` and `b_i` values sampled with `start_i`.
- R2: If `start_i` is accepted at rising edge 0, `done_o` first reads high after rising edge 2·(OP_W/16)+2. For the default 64-bit operands this is edge 10.
- R3: `done_o` is high for exactly one cycle per run.
- R4: `prod_o` changes only on the edge that raises `done_o`. It holds its value until the next run completes.
- R5: A `start_i` pulse that arrives while a run is in progress is ignored. The current product, its timing and the output are unaffected, and no extra done pulse follows.
- R6: While `rst_ni` is low, `done_o` is 0 and `prod_o` is 0.
- R7: Operands with every bit set give the exact product. Column sums of 16 bits × 2 plus log2 of the word count never overflow.
- R8: Changing `a_i` or `b_i` after the start edge has no effect on the result.
- R9: A `start_i` sampled while `done_o` is high starts a new run with the normal latency.
- R10: OP_W must be a multiple of 16. Narrower values are zero-extended at the top by the user.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load operands and begin; ignored while a run is in progress |
| a_i | input | OP_W | Multiplicand |
| b_i | input | OP_W | Multiplier |
| prod_o | output | 2·OP_W | Product, held between runs |
| done_o | output | 1 | One-cycle pulse when `prod_o` is updated |

## Verification
Different internal faults show up at the ports in different ways:
- A misrouted or mistimed word in either shift register puts a wrong partial product into one column. That shows up as a wrong `prod_o` at the done pulse of the same run, in bits at and above 16 times that column's index.
- A miscounted sequencer moves the done pulse away from its expected edge.
- A control path that lets a second start through produces either a late, extra done pulse or a product built from the second operands.
- Guard-bit loss shows up only with dense operands, so the all-ones vector is the one that exposes it.

// File: rtl/comba_pkg.sv
package comba_pkg;
  localparam int unsigned WORD_W_DEF = 16;

  function automatic int unsigned guard_bits(input int unsigned words);
    return (words > 1) ? $clog2(words) : 0;
  endfunction
endpackage

// File: rtl/comba_lane.sv
module comba_lane #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0]   a_i,
  input  logic [WORD_W-1:0]   b_i,
  output logic [2*WORD_W-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/comba_colsum.sv
module comba_colsum #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NW     = 4,
  parameter int unsigned COL_W  = 2*WORD_W + comba_pkg::guard_bits(NW)
) (
  input  logic [NW-1:0][2*WORD_W-1:0] p_i,
  output logic [COL_W-1:0]            sum_o
);
  logic [COL_W:0] wide;

  always_comb begin
    wide = '0;
    for (int j = 0; j < NW; j++) wide = wide + (COL_W+1)'(p_i[j]);
  end

  assign sum_o = wide[COL_W-1:0];

  // R7: guard bits suffice for the worst column
  always_comb begin
    p_no_overflow_r7: assert (wide[COL_W] == 1'b0);
  end
endmodule

// File: rtl/comba_ctrl.sv
module comba_ctrl #(
  parameter int unsigned NW = 4,
  localparam int unsigned LAST = 2*NW + 2,
  localparam int unsigned CNT_W = $clog2(LAST + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             shift_o,
  output logic [CNT_W-1:0] shift_idx_o,
  output logic             finish_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(LAST)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign load_o      = !busy_q && start_i;
  assign shift_o     = busy_q && (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(2*NW-1));
  assign shift_idx_o = cnt_q - 1'b1;
  assign finish_o    = busy_q && (cnt_q == CNT_W'(LAST));

  // R5: a busy sequencer never jumps back to step 1
  p_busy_advance_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (cnt_q != CNT_W'(LAST)) |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/comba_mult.sv
module comba_mult #(
  parameter int unsigned WORD_W = comba_pkg::WORD_W_DEF,
  parameter int unsigned OP_W   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] prod_o,
  output logic              done_o
);
  localparam int unsigned NW     = OP_W / WORD_W;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned COL_W  = 2*WORD_W + comba_pkg::guard_bits(NW);
  localparam int unsigned LAST   = 2*NW + 2;
  localparam int unsigned CNT_W  = $clog2(LAST + 1) + 1;

  logic             busy, load, shift, finish;
  logic [CNT_W-1:0] shift_idx;

  comba_ctrl #(.NW(NW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy),
    .load_o      (load),
    .shift_o     (shift),
    .shift_idx_o (shift_idx),
    .finish_o    (finish)
  );

  // A words fixed per lane; B drains down from b_hold, travels up in b_trv
  logic [NW-1:0][WORD_W-1:0] a_q, b_hold, b_trv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_hold <= '0;
      b_trv  <= '0;
    end else if (load) begin
      a_q    <= a_i;
      b_hold <= b_i;
      b_trv  <= '0;
    end else if (shift) begin
      b_trv[0]         <= b_hold[0];
      b_hold[NW-1]     <= '0;
      for (int j = 1; j < NW; j++) begin
        b_trv[j]    <= b_trv[j-1];
        b_hold[j-1] <= b_hold[j];
      end
    end
  end

  logic [NW-1:0][2*WORD_W-1:0] lane_p;

  for (genvar g = 0; g < NW; g++) begin : g_lane
    comba_lane #(.WORD_W(WORD_W)) u_lane (
      .a_i (a_q[g]),
      .b_i (b_trv[g]),
      .p_o (lane_p[g])
    );
  end

  logic [COL_W-1:0] col_sum;

  comba_colsum #(.WORD_W(WORD_W), .NW(NW), .COL_W(COL_W)) u_colsum (
    .p_i   (lane_p),
    .sum_o (col_sum)
  );

  logic             sh_vld, col_vld;
  logic [CNT_W-1:0] sh_idx, col_idx;
  logic [COL_W-1:0] col_q;
  logic [PROD_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_vld  <= 1'b0;
      sh_idx  <= '0;
      col_vld <= 1'b0;
      col_idx <= '0;
      col_q   <= '0;
    end else begin
      sh_vld  <= shift && !load;
      sh_idx  <= shift_idx;
      col_vld <= sh_vld && !load;
      col_idx <= sh_idx;
      col_q   <= col_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (load) begin
      acc_q <= '0;
    end else if (col_vld) begin
      acc_q <= acc_q + (PROD_W'(col_q) << (WORD_W * col_idx));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) prod_o <= acc_q;
    end
  end

  // latency checker
  logic [CNT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lat_q <= '0;
    else if (load)  lat_q <= '0;
    else if (busy)  lat_q <= lat_q + 1'b1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == CNT_W'(LAST)));

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_prod_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(prod_o));

  p_start_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i |=> (a_q == $past(a_q)));

  p_col_in_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_vld |-> (col_idx <= CNT_W'(2*NW-2)));

  initial begin
    p_width_multiple_r10: assert (OP_W % WORD_W == 0 && NW >= 1);
  end
endmodule

// File: tb/comba_mult_tb.sv
module comba_mult_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OP_W = 64;
  localparam int LAT  = 2*(OP_W/16) + 2;
  localparam int NV   = 8;

  localparam logic [OP_W-1:0] VA [NV] = '{
    64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
    64'hAAAA_5555_AAAA_5555, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_FFFF_0001, 64'hDEAD_BEEF_CAFE_F00D};
  localparam logic [OP_W-1:0] VB [NV] = '{
    64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001,
    64'h5555_AAAA_5555_AAAA, 64'hFEDC_BA98_7654_3210, 64'h0001_0000_0000_FFFF, 64'h1357_9BDF_2468_ACE0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [OP_W-1:0] a_i = '0, b_i = '0;
  logic [2*OP_W-1:0] prod_o;
  logic done_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  comba_mult #(.OP_W(OP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .prod_o(prod_o), .done_o(done_o)
  );

  function automatic logic [2*OP_W-1:0] ref_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    return {{OP_W{1'b0}}, a} * {{OP_W{1'b0}}, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*OP_W-1:0] act, input logic [2*OP_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive start at a negedge; returns after the accepting edge
  task automatic kick(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic full_run(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string req);
    int n;
    logic [2*OP_W-1:0] exp;
    exp = ref_mul(a, b);
    kick(a, b);
    wait_done(n);
    chk(n == LAT, "R2 latency", 128'(n), 128'(LAT));
    chk(prod_o == exp, req, prod_o, exp);
    @(negedge clk);
    chk(!done_o, "R3 done one cycle", 128'(done_o), 128'(0));
    repeat (3) @(negedge clk);
    chk(prod_o == exp, "R4 product held", prod_o, exp);
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [2*OP_W-1:0] e1, e2;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R6 reset done", 128'(done_o), 128'(0));
    chk(prod_o == '0, "R6 reset product", prod_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      full_run(VA[i], VB[i], (i == 2) ? "R7 all ones" : "R1 product");
    end

    // R5: second start during a run is ignored
    e1 = ref_mul(VA[5], VB[5]);
    kick(VA[5], VB[5]);
    @(negedge clk);
    a_i = VA[7]; b_i = VB[7]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    chk(n + 2 == LAT, "R5 latency unaffected", 128'(n + 2), 128'(LAT));
    chk(prod_o == e1, "R5 first operands kept", prod_o, e1);
    n = 0;
    repeat (LAT + 4) begin
      @(negedge clk);
      if (done_o) n++;
    end
    chk(n == 0, "R5 no extra done", 128'(n), 128'(0));

    // R8: operand inputs change mid-run
    e1 = ref_mul(VA[7], VB[6]);
    kick(VA[7], VB[6]);
    a_i = '1; b_i = 64'h5A5A;
    wait_done(n);
    chk(prod_o == e1, "R8 late operand change", prod_o, e1);

    // R9: start while done is high
    e2 = ref_mul(VA[4], VB[3]);
    kick(VA[4], VB[3]);
    wait_done(n);
    chk(n == LAT, "R9 latency back-to-back", 128'(n), 128'(LAT));
    chk(prod_o == e2, "R9 product back-to-back", prod_o, e2);

    // R10: narrow value zero-extended
    e1 = ref_mul(64'h0000_0000_0000_BEEF, 64'h0000_0000_0000_0FF1);
    full_run(64'h0000_0000_0000_BEEF, 64'h0000_0000_0000_0FF1, "R10 narrow zero-extended");

    // R6: reset mid-run clears outputs
    kick(VA[3], VB[3]);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(prod_o == '0 && !done_o, "R6 reset mid-run", prod_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    full_run(VA[6], VB[6], "R1 after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule